// File: doc/BRIEF.md
# Exception Entry Sequencer

This block walks a processor core through the entry half of exception handling. When the core raises a request, the sequencer takes a snapshot of the status word and switches it into supervisor mode. It then forms the vector address from a software-relocatable table base and an 8-bit vector number. It pushes a four-halfword context frame onto the supervisor stack and reads the handler address from the vector table. The vector number comes from the core's own logic or from an external device input, and each request selects which.

A reset request is handled as a special case. It pushes no frame and reads two longwords from the start of the table: the first gives the new supervisor stack pointer and the second gives the new program counter. Every memory cycle carries a 3-bit address-space tag. Reset fetches are tagged as supervisor program space, and every other cycle is tagged as supervisor data space.

The table base register sits inside the block. It has a write port and a read-out port. While a sequence is running, writes to it are refused.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, `vbrValue` is 0, `busy` and `done` are 0, `newSr` is 0, and no memory cycle is issued until a request arrives.
- R2: A base-register write while idle shows on `vbrValue` one cycle later. A write while `busy` is 1 is dropped.
- R3: A non-reset request reads the handler address at `vbrValue + 4*vector`, with `memFc` = 5 (supervisor data space).
- R4: The vector number is `extVec` when `reqUseExt` is 1 and `reqIntVec` otherwise. A reset request always uses vector 0.
- R5: `newSr` is the request's `curSr` with bit 13 (supervisor) set and bit 15 (trace) cleared. A reset request also sets bits 10:8 (interrupt mask) to 7. All other bits are unchanged.
- R6: A non-reset entry makes exactly four 16-bit writes, all with `memFc` = 5, in this order: format/offset word at SSP-2, PC[15:0] at SSP-4, PC[31:16] at SSP-6, then the old SR at SSP-8. Here SSP is `curSsp` at the request.
- R7: The format/offset word is `{FRAME_FMT[3:0], vector*4 as 12 bits}`.
- R8: A reset request makes no writes. It reads `vbrValue+0` and then `vbrValue+4`, both with `memFc` = 6. The first word becomes `newSsp` and the second becomes `newPc`.
- R9: After a non-reset entry, `newSsp` equals `curSsp - 8`.
- R10: `done` is a one-cycle pulse in the cycle after the handler word is captured, with `newPc` already valid. Requests made while `busy` is 1 are ignored.
- R11: A base-register write in the same cycle a request is accepted is used for that request's vector address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Exception request strobe |
| reqIsReset | input | 1 | Request is the reset exception |
| reqUseExt | input | 1 | Take the vector number from `extVec` |
| reqIntVec | input | 8 | Internally supplied vector number |
| extVec | input | 8 | Vector number from an external device |
| curSr | input | 16 | Status word at the request |
| curPc | input | 32 | Program counter at the request |
| curSsp | input | 32 | Supervisor stack pointer at the request |
| vbrWrEn | input | 1 | Base register write enable |
| vbrWrData | input | 32 | Base register write data |
| vbrValue | output | 32 | Current base register contents |
| memWrEn | output | 1 | Stack write strobe |
| memWrAddr | output | 32 | Stack write byte address |
| memWrData | output | 16 | Stack write data |
| memRdEn | output | 1 | Vector read strobe |
| memRdAddr | output | 32 | Vector read byte address |
| memRdData | input | 32 | Read data, valid the cycle after `memRdEn` |
| memFc | output | 3 | Address-space tag of the current cycle |
| newSr | output | 16 | Status word for the handler |
| newPc | output | 32 | Handler address |
| newSsp | output | 32 | Supervisor stack pointer for the handler |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Entry complete pulse |

## Verification
A base-register write can land in the same cycle that a request is accepted. The question is whether the vector address is built from the old base or the new one. The bench drives `vbrWrEn` and `reqValid` on the same edge and has the scoreboard expect a read at the new base plus offset (R11). A second collision is a fresh request together with a base write while a sequence runs. The bench injects both mid-sequence and judges them by the absence of extra memory cycles in the scoreboard and by an unchanged `vbrValue`.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam logic [2:0] FC_SUP_DATA = 3'd5;
  localparam logic [2:0] FC_SUP_PROG = 3'd6;
  localparam int SR_T_BIT = 15;
  localparam int SR_S_BIT = 13;
  localparam int SR_MASK_LO = 8;
  localparam int FRAME_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_PUSH, ST_RDSSP, ST_RDPC, ST_LOADPC, ST_FIN
  } seqStateT;

  typedef struct packed {
    logic       accept;
    logic       calcVec;
    logic       wrEn;
    logic [1:0] wrSel;
    logic       rdEn;
    logic       rdSecond;
    logic       progSpace;
    logic       capSsp;
    logic       capPc;
  } seqStrobeT;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqIsReset,
  output seqStrobeT strb,
  output logic      busy,
  output logic      done
);
  seqStateT state, nextState;
  logic isReset;
  logic [1:0] pushCnt;

  always_comb begin
    strb = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        strb.accept = 1'b1;
        nextState = ST_VEC;
      end
      ST_VEC: begin
        strb.calcVec = 1'b1;
        nextState = isReset ? ST_RDSSP : ST_PUSH;
      end
      ST_PUSH: begin
        strb.wrEn = 1'b1;
        strb.wrSel = pushCnt;
        if (pushCnt == 2'd3) nextState = ST_RDPC;
      end
      ST_RDSSP: begin
        strb.rdEn = 1'b1;
        strb.progSpace = 1'b1;
        nextState = ST_RDPC;
      end
      ST_RDPC: begin
        strb.rdEn = 1'b1;
        strb.rdSecond = isReset;
        strb.progSpace = isReset;
        strb.capSsp = isReset;
        nextState = ST_LOADPC;
      end
      ST_LOADPC: begin
        strb.capPc = 1'b1;
        nextState = ST_FIN;
      end
      ST_FIN: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isReset <= 1'b0;
      pushCnt <= 2'd0;
    end else begin
      state <= nextState;
      if (strb.accept) begin
        isReset <= reqIsReset;
        pushCnt <= 2'd0;
      end else if (strb.wrEn) begin
        pushCnt <= pushCnt + 2'd1;
      end
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_busy_noaccept_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.accept);
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W = 8,
  parameter int SR_W = 16,
  parameter logic [3:0] FRAME_FMT = 4'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  logic              busy,
  input  logic              reqIsReset,
  input  logic              reqUseExt,
  input  logic [VEC_W-1:0]  reqIntVec,
  input  logic [VEC_W-1:0]  extVec,
  input  logic [SR_W-1:0]   curSr,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] curSsp,
  input  logic              vbrWrEn,
  input  logic [ADDR_W-1:0] vbrWrData,
  input  logic [ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0] vbrValue,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [15:0]       memWrData,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [2:0]        memFc,
  output logic [SR_W-1:0]   newSr,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] newSsp
);
  localparam int OFF_W = VEC_W + 2;

  logic [ADDR_W-1:0] vbrReg, savedPc, sspBase, vecAddr, pcReg, sspReg;
  logic [SR_W-1:0]   tempSr, workSr, srNext;
  logic [VEC_W-1:0]  vecNum, vecSel;
  logic [15:0]       fmtWord;
  logic [ADDR_W-1:0] wrOffset;

  always_comb begin
    srNext = curSr;
    srNext[SR_S_BIT] = 1'b1;
    srNext[SR_T_BIT] = 1'b0;
    if (reqIsReset) srNext[SR_MASK_LO +: 3] = 3'b111;
    vecSel = reqIsReset ? '0 : (reqUseExt ? extVec : reqIntVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vbrReg <= '0; tempSr <= '0; workSr <= '0; savedPc <= '0;
      sspBase <= '0; vecNum <= '0; vecAddr <= '0; pcReg <= '0; sspReg <= '0;
    end else begin
      if (vbrWrEn && !busy) vbrReg <= vbrWrData;
      if (strb.accept) begin
        tempSr <= curSr;
        workSr <= srNext;
        savedPc <= curPc;
        sspBase <= curSsp;
        vecNum <= vecSel;
        if (!reqIsReset) sspReg <= curSsp - ADDR_W'(FRAME_BYTES);
      end
      if (strb.calcVec) vecAddr <= vbrReg + ADDR_W'({vecNum, 2'b00});
      if (strb.capSsp) sspReg <= memRdData;
      if (strb.capPc) pcReg <= memRdData;
    end
  end

  assign fmtWord = {FRAME_FMT, (12 - OFF_W)'(0), vecNum, 2'b00};
  assign wrOffset = ADDR_W'({strb.wrSel, 1'b0}) + ADDR_W'(2);

  always_comb begin
    case (strb.wrSel)
      2'd0: memWrData = fmtWord;
      2'd1: memWrData = savedPc[15:0];
      2'd2: memWrData = savedPc[31:16];
      default: memWrData = tempSr;
    endcase
  end

  assign memWrEn = strb.wrEn;
  assign memWrAddr = sspBase - wrOffset;
  assign memRdEn = strb.rdEn;
  assign memRdAddr = vecAddr + (strb.rdSecond ? ADDR_W'(4) : '0);
  assign memFc = (strb.rdEn && strb.progSpace) ? FC_SUP_PROG : FC_SUP_DATA;
  assign vbrValue = vbrReg;
  assign newSr = workSr;
  assign newPc = pcReg;
  assign newSsp = sspReg;

  assert_vbr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && vbrWrEn) |=> $stable(vbrValue));
  assert_wr_space_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> memFc == FC_SUP_DATA);
  assert_wr_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ((sspBase - memWrAddr) <= ADDR_W'(FRAME_BYTES)) && (sspBase != memWrAddr));
  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter logic [3:0] FRAME_FMT = 4'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqIsReset,
  input  logic        reqUseExt,
  input  logic [7:0]  reqIntVec,
  input  logic [7:0]  extVec,
  input  logic [15:0] curSr,
  input  logic [31:0] curPc,
  input  logic [31:0] curSsp,
  input  logic        vbrWrEn,
  input  logic [31:0] vbrWrData,
  output logic [31:0] vbrValue,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [15:0] memWrData,
  output logic        memRdEn,
  output logic [31:0] memRdAddr,
  input  logic [31:0] memRdData,
  output logic [2:0]  memFc,
  output logic [15:0] newSr,
  output logic [31:0] newPc,
  output logic [31:0] newSsp,
  output logic        busy,
  output logic        done
);
  seqStrobeT strb;

  exc_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsReset(reqIsReset),
    .strb(strb), .busy(busy), .done(done)
  );

  exc_entry_dp #(.ADDR_W(32), .VEC_W(8), .SR_W(16), .FRAME_FMT(FRAME_FMT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy),
    .reqIsReset(reqIsReset), .reqUseExt(reqUseExt), .reqIntVec(reqIntVec),
    .extVec(extVec), .curSr(curSr), .curPc(curPc), .curSsp(curSsp),
    .vbrWrEn(vbrWrEn), .vbrWrData(vbrWrData), .memRdData(memRdData),
    .vbrValue(vbrValue), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memFc(memFc), .newSr(newSr), .newPc(newPc), .newSsp(newSsp)
  );

  assert_done_after_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strb.capPc));
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqIsReset = 1'b0, reqUseExt = 1'b0;
  logic [7:0] reqIntVec = '0, extVec = '0;
  logic [15:0] curSr = '0;
  logic [31:0] curPc = '0, curSsp = '0;
  logic vbrWrEn = 1'b0;
  logic [31:0] vbrWrData = '0;
  logic [31:0] vbrValue, memWrAddr, memRdAddr, newPc, newSsp;
  logic [31:0] memRdData = '0;
  logic [15:0] memWrData, newSr;
  logic memWrEn, memRdEn, busy, done;
  logic [2:0] memFc;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] vbrModel = '0;
  logic [67:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsReset(reqIsReset),
    .reqUseExt(reqUseExt), .reqIntVec(reqIntVec), .extVec(extVec),
    .curSr(curSr), .curPc(curPc), .curSsp(curSsp), .vbrWrEn(vbrWrEn),
    .vbrWrData(vbrWrData), .vbrValue(vbrValue), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memFc(memFc),
    .newSr(newSr), .newPc(newPc), .newSsp(newSsp), .busy(busy), .done(done)
  );

  function automatic logic [31:0] memFn(logic [31:0] a, logic [2:0] fc);
    return a * 32'd3 + {29'd0, fc};
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memFn(memRdAddr, memFc);

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected memory cycles in order
  always @(negedge clk) begin
    if (rstN && (memWrEn || memRdEn)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected memory cycle", memWrEn ? memWrAddr : memRdAddr, 32'h0);
      end else begin
        logic [67:0] e;
        e = expQ.pop_front();
        check(memWrEn == !e[67], "R6/R8", "cycle kind", {31'd0, memWrEn}, {31'd0, !e[67]});
        check((memWrEn ? memWrAddr : memRdAddr) == e[66:35], "R3/R6/R8", "address",
              memWrEn ? memWrAddr : memRdAddr, e[66:35]);
        if (memWrEn)
          check(memWrData == e[18:3], "R6/R7", "write data", {16'd0, memWrData}, {16'd0, e[18:3]});
        check(memFc == e[2:0], "R3/R8", "space tag", {29'd0, memFc}, {29'd0, e[2:0]});
      end
    end
  end

  task automatic runEntry(bit isRst, bit useExt, logic [7:0] intV, logic [7:0] extV,
                          logic [15:0] sr, logic [31:0] pc, logic [31:0] ssp,
                          bit wrVbr, logic [31:0] vbrNew, bit inject);
    logic [7:0] vec;
    logic [31:0] va, expPc, expSsp;
    logic [15:0] expSr;
    int guard;
    if (wrVbr) vbrModel = vbrNew;
    vec = isRst ? 8'd0 : (useExt ? extV : intV);
    va = vbrModel + {22'd0, vec, 2'b00};
    expSr = sr | 16'h2000;
    expSr[15] = 1'b0;
    if (isRst) expSr[10:8] = 3'b111;
    if (isRst) begin
      expQ.push_back({1'b1, va, 32'd0, 3'd6});
      expQ.push_back({1'b1, va + 32'd4, 32'd0, 3'd6});
      expSsp = memFn(va, 3'd6);
      expPc = memFn(va + 32'd4, 3'd6);
    end else begin
      expQ.push_back({1'b0, ssp - 32'd2, 16'd0, 4'h0, 2'b00, vec, 2'b00, 3'd5});
      expQ.push_back({1'b0, ssp - 32'd4, 16'd0, pc[15:0], 3'd5});
      expQ.push_back({1'b0, ssp - 32'd6, 16'd0, pc[31:16], 3'd5});
      expQ.push_back({1'b0, ssp - 32'd8, 16'd0, sr, 3'd5});
      expQ.push_back({1'b1, va, 32'd0, 3'd5});
      expSsp = ssp - 32'd8;
      expPc = memFn(va, 3'd5);
    end
    @(negedge clk);
    reqValid = 1'b1; reqIsReset = isRst; reqUseExt = useExt;
    reqIntVec = intV; extVec = extV; curSr = sr; curPc = pc; curSsp = ssp;
    vbrWrEn = wrVbr; vbrWrData = vbrNew;
    @(negedge clk);
    reqValid = 1'b0; vbrWrEn = 1'b0;
    reqIntVec = 8'h5A; extVec = 8'hA5;
    check(busy == 1'b1, "R10", "busy after accept", {31'd0, busy}, 32'd1);
    check(newSr == expSr, "R5", "status word", {16'd0, newSr}, {16'd0, expSr});
    if (inject) begin
      @(negedge clk);
      reqValid = 1'b1; reqIntVec = 8'h11; vbrWrEn = 1'b1; vbrWrData = 32'hDEAD_0000;
      @(negedge clk);
      reqValid = 1'b0; vbrWrEn = 1'b0;
    end
    guard = 0;
    while (!done && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, "R10", "done reached", {31'd0, done}, 32'd1);
    check(newPc == expPc, "R3/R8", "new PC", newPc, expPc);
    check(newSsp == expSsp, isRst ? "R8" : "R9", "new SSP", newSsp, expSsp);
    check(vbrValue == vbrModel, "R2", "base held", vbrValue, vbrModel);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10", "done pulse width", {30'd0, busy, done}, 32'd0);
    check(expQ.size() == 0, "R6/R8", "all cycles seen", expQ.size(), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun + 1, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(vbrValue == 32'd0, "R1", "base after reset", vbrValue, 32'd0);
    check(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {30'd0, busy, done}, 32'd0);
    check(newSr == 16'd0, "R1", "status after reset", {16'd0, newSr}, 32'd0);
    check(!memWrEn && !memRdEn, "R1", "no cycles", {30'd0, memWrEn, memRdEn}, 32'd0);
    // R2 idle write
    vbrWrEn = 1'b1; vbrWrData = 32'h0001_0000;
    @(negedge clk);
    vbrWrEn = 1'b0; vbrModel = 32'h0001_0000;
    check(vbrValue == 32'h0001_0000, "R2", "idle base write", vbrValue, 32'h0001_0000);
    // R3 R4 R5 R6 R7 R9: internal vector
    runEntry(1'b0, 1'b0, 8'h40, 8'h99, 16'h8213, 32'h1234_5678, 32'h0000_2000, 1'b0, 32'h0, 1'b0);
    // R4 external vector, R11 same-cycle base write
    runEntry(1'b0, 1'b1, 8'h07, 8'hFF, 16'h0004, 32'hCAFE_0002, 32'h0010_0000, 1'b1, 32'h0002_0000, 1'b0);
    // R8 reset request
    runEntry(1'b1, 1'b1, 8'h33, 8'h44, 16'h8000, 32'h0, 32'h0, 1'b0, 32'h0, 1'b0);
    // R10 R2 request and base write during busy are ignored
    runEntry(1'b0, 1'b0, 8'h02, 8'h00, 16'hA71F, 32'h0000_0400, 32'h0000_8000, 1'b0, 32'h0, 1'b1);
    runEntry(1'b1, 1'b0, 8'h00, 8'h00, 16'h2000, 32'h0, 32'h0, 1'b1, 32'h0003_0000, 1'b1);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0 && !busy, "R10", "quiet after runs", expQ.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule